// File: doc/BRIEF.md
# Software Interrupt Entry and Return Sequencer

This block performs the memory side of interrupt entry and interrupt return for a 16-bit core with segmented addressing. The core's decoder presents a request that carries an operation code, an 8-bit vector number and a snapshot of the architectural state: flags word, code segment, instruction pointer, stack segment and stack pointer. The sequencer then runs a fixed series of 16-bit word accesses over a request/acknowledge memory port. When the series is complete it reports the new code segment, instruction pointer, stack pointer and flags with a one-cycle completion pulse.

On entry the sequencer saves the flags, then the return code segment, then the return instruction pointer on the stack. It then fetches the handler address from the vector table at the bottom of physical memory and clears the trap and interrupt-enable flags. The overflow-trap variant does the same through vector 4, but only when the overflow flag is set. Otherwise it finishes at once without touching memory. On return it pops the instruction pointer, the code segment and the flags word, in that order. The decoder presents the single-byte breakpoint form as an ordinary request with type 3.

The control is a single state machine with states `S_IDLE`, `S_PUSH_FL`, `S_PUSH_CS`, `S_PUSH_IP`, `S_VEC_IP`, `S_VEC_CS`, `S_POP_IP`, `S_POP_CS`, `S_POP_FL` and `S_FINISH`. It has the following transitions:
- `S_IDLE` goes to `S_PUSH_FL` on an accepted entry request, to `S_POP_IP` on an accepted return request, and to `S_FINISH` on an accepted overflow-trap request whose overflow flag is clear.
- The states advance `S_PUSH_FL` → `S_PUSH_CS` → `S_PUSH_IP` → `S_VEC_IP` → `S_VEC_CS` → `S_FINISH`, each step taken on an acknowledge.
- The states advance `S_POP_IP` → `S_POP_CS` → `S_POP_FL` → `S_FINISH`, each step taken on an acknowledge.
- `S_FINISH` always goes to `S_IDLE`.

Top module: `swint_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and `out_flags`, `out_cs`, `out_ip` and `out_sp` are zero.
- R2: An entry request (`req_op` = 0, type n) first issues three word writes in this order:
  - the flags word, unmodified, at SS*16 + (SP-2);
  - CS at SS*16 + (SP-4);
  - IP at SS*16 + (SP-6).
  Offsets wrap modulo 2^16 and physical addresses wrap modulo 2^20.
- R3: After the writes, an entry issues two word reads: the new IP at byte address 4*n, then the new CS at 4*n+2.
- R4: When an entry completes, the result ports hold the following:
  - `out_ip` and `out_cs` hold the two vector words;
  - `out_sp` is SP-6 modulo 2^16;
  - `out_flags` is the input flags with bit 8 (trap) and bit 9 (interrupt enable) cleared.
- R5: An overflow-trap request (`req_op` = 1) whose flags bit 11 (overflow) is set behaves exactly like an entry with type 4, whatever `req_type` holds.
- R6: An overflow-trap request with bit 11 clear makes no memory access. It raises `done` in the cycle after acceptance, and the result ports then equal the request's flags, CS, IP and SP.
- R7: A return request (`req_op` = 2) issues three reads at SS*16 + SP, SS*16 + (SP+2) and SS*16 + (SP+4). The words read become `out_ip`, `out_cs` and `out_flags`, the flags taken unmasked. `out_sp` is SP+6 modulo 2^16.
- R8: Each access holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until a cycle with `mem_ack` high ends it. The next access of the series is presented in the following cycle, and `mem_req` is high only while `busy` is high.
- R9: `busy` rises in the cycle after acceptance and stays high through the cycle of `done`. `done` is a one-cycle pulse in the cycle after the final acknowledge, with `mem_req` low. `busy` is low in the cycle after `done`.
- R10: A request presented while `busy` is high is ignored. A request with the reserved code `req_op` = 3 is ignored and leaves `busy` low and the result ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 entry, 1 overflow trap, 2 return, 3 reserved |
| req_type | input | 8 | Vector number for an entry request |
| in_flags | input | 16 | Current flags word |
| in_cs | input | 16 | Current code segment |
| in_ip | input | 16 | Current instruction pointer (return address) |
| in_ss | input | 16 | Stack segment |
| in_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete in this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| out_flags | output | 16 | Resulting flags word |
| out_cs | output | 16 | Resulting code segment |
| out_ip | output | 16 | Resulting instruction pointer |
| out_sp | output | 16 | Resulting stack pointer |

## Verification
The first access of a sequence is due in the cycle right after the accepting edge. Each later access is due in the cycle after the acknowledge that closed the previous one. `done` is due one cycle after the last acknowledge, or one cycle after acceptance for an untaken overflow trap, and the result ports are valid in that same cycle. The bench model keeps the expected accesses in a queue. On every falling edge it compares the presented access, `busy` and `done` against the head of the queue, and it pops the head only when it drives an acknowledge. Acknowledge delays of zero, one and two cycles therefore shift every later expectation by exactly the inserted wait cycles.

// File: rtl/swint_pkg.sv
package swint_pkg;

    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_INTO = 2'd1,
        OP_IRET = 2'd2,
        OP_RSVD = 2'd3
    } swint_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_VEC_IP,
        S_VEC_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_FL,
        S_FINISH
    } swint_state_e;

endpackage

// File: rtl/swint_phys_addr.sv
// Segment:offset to physical byte address, wrapping at the address width.
module swint_phys_addr #(
    parameter int W         = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [W-1:0]           seg,
    input  logic [W-1:0]           off,
    output logic [W+SEG_SHIFT-1:0] phys
);
    localparam int AW = W + SEG_SHIFT;

    logic [AW-1:0] seg_ext;
    logic [AW-1:0] off_ext;

    assign seg_ext = {seg, {SEG_SHIFT{1'b0}}};
    assign off_ext = AW'(off);
    assign phys    = seg_ext + off_ext;
endmodule

// File: rtl/swint_flag_clr.sv
// Produces the flags word seen by a handler: trap and interrupt-enable cleared.
module swint_flag_clr #(
    parameter int W      = 16,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9
) (
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] flags_out
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == TF_BIT || i == IF_BIT) begin : g_clr
                assign flags_out[i] = 1'b0;
            end else begin : g_pass
                assign flags_out[i] = flags_in[i];
            end
        end
    endgenerate
endmodule

// File: rtl/swint_seq.sv
module swint_seq
    import swint_pkg::*;
#(
    parameter int W         = 16,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    parameter int TF_BIT    = 8,
    parameter int IF_BIT    = 9,
    parameter int OF_BIT    = 11,
    parameter int OVF_TYPE  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [TYPE_W-1:0]      req_type,
    input  logic [W-1:0]           in_flags,
    input  logic [W-1:0]           in_cs,
    input  logic [W-1:0]           in_ip,
    input  logic [W-1:0]           in_ss,
    input  logic [W-1:0]           in_sp,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [W+SEG_SHIFT-1:0] mem_addr,
    output logic [W-1:0]           mem_wdata,
    input  logic                   mem_ack,
    input  logic [W-1:0]           mem_rdata,
    output logic                   busy,
    output logic                   done,
    output logic [W-1:0]           out_flags,
    output logic [W-1:0]           out_cs,
    output logic [W-1:0]           out_ip,
    output logic [W-1:0]           out_sp
);
    localparam int             AW        = W + SEG_SHIFT;
    localparam int             VEC_SHIFT = 2;           // 4-byte vector entries
    localparam logic [W-1:0]   STEP      = W'(W / 8);   // bytes per word

    swint_state_e state, state_nx;
    swint_op_e    op_in;

    logic [W-1:0]      flags_q, cs_q, ip_q, ss_q, sp_q;
    logic [W-1:0]      res_ip_q, res_cs_q;
    logic [TYPE_W-1:0] vec_q;
    logic [W-1:0]      ent_flags;
    logic [W-1:0]      stk_off;
    logic [AW-1:0]     stk_addr;
    logic [AW-1:0]     vec_base;
    logic              accept;
    logic              ovf_in;
    logic              skip_trap;
    logic              push_st;

    assign op_in     = swint_op_e'(req_op);
    assign accept    = req_valid && (state == S_IDLE) && (op_in != OP_RSVD);
    assign ovf_in    = in_flags[OF_BIT];
    assign skip_trap = (op_in == OP_INTO) && !ovf_in;
    assign push_st   = (state == S_PUSH_FL) || (state == S_PUSH_CS) || (state == S_PUSH_IP);

    // Stack address: pre-decrement on push, current pointer on pop.
    assign stk_off  = push_st ? (sp_q - STEP) : sp_q;
    assign vec_base = AW'(vec_q) << VEC_SHIFT;

    swint_phys_addr #(.W(W), .SEG_SHIFT(SEG_SHIFT)) u_stk_addr (
        .seg  (ss_q),
        .off  (stk_off),
        .phys (stk_addr)
    );

    swint_flag_clr #(.W(W), .TF_BIT(TF_BIT), .IF_BIT(IF_BIT)) u_flag_clr (
        .flags_in  (flags_q),
        .flags_out (ent_flags)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (skip_trap)              state_nx = S_FINISH;
                    else if (op_in == OP_IRET)  state_nx = S_POP_IP;
                    else                        state_nx = S_PUSH_FL;
                end
            end
            S_PUSH_FL: if (mem_ack) state_nx = S_PUSH_CS;
            S_PUSH_CS: if (mem_ack) state_nx = S_PUSH_IP;
            S_PUSH_IP: if (mem_ack) state_nx = S_VEC_IP;
            S_VEC_IP:  if (mem_ack) state_nx = S_VEC_CS;
            S_VEC_CS:  if (mem_ack) state_nx = S_FINISH;
            S_POP_IP:  if (mem_ack) state_nx = S_POP_CS;
            S_POP_CS:  if (mem_ack) state_nx = S_POP_FL;
            S_POP_FL:  if (mem_ack) state_nx = S_FINISH;
            S_FINISH:               state_nx = S_IDLE;
            default:                state_nx = S_IDLE;
        endcase
    end

    // Bus and status outputs, decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_PUSH_FL: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr; mem_wdata = flags_q;
            end
            S_PUSH_CS: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr; mem_wdata = cs_q;
            end
            S_PUSH_IP: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr; mem_wdata = ip_q;
            end
            S_VEC_IP: begin
                mem_req = 1'b1; mem_addr = vec_base;
            end
            S_VEC_CS: begin
                mem_req = 1'b1; mem_addr = vec_base + AW'(STEP);
            end
            S_POP_IP, S_POP_CS, S_POP_FL: begin
                mem_req = 1'b1; mem_addr = stk_addr;
            end
            S_IDLE, S_FINISH: begin
                mem_req = 1'b0;
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);

    // Working registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q   <= '0;
            cs_q      <= '0;
            ip_q      <= '0;
            ss_q      <= '0;
            sp_q      <= '0;
            vec_q     <= '0;
            res_ip_q  <= '0;
            res_cs_q  <= '0;
            out_flags <= '0;
            out_cs    <= '0;
            out_ip    <= '0;
            out_sp    <= '0;
        end else begin
            if (accept) begin
                flags_q <= in_flags;
                cs_q    <= in_cs;
                ip_q    <= in_ip;
                ss_q    <= in_ss;
                sp_q    <= in_sp;
                vec_q   <= (op_in == OP_INTO) ? TYPE_W'(OVF_TYPE) : req_type;
                if (skip_trap) begin
                    out_flags <= in_flags;
                    out_cs    <= in_cs;
                    out_ip    <= in_ip;
                    out_sp    <= in_sp;
                end
            end
            if (mem_ack) begin
                case (state)
                    S_PUSH_FL, S_PUSH_CS, S_PUSH_IP: begin
                        sp_q <= sp_q - STEP;
                    end
                    S_VEC_IP: begin
                        res_ip_q <= mem_rdata;
                    end
                    S_VEC_CS: begin
                        out_cs    <= mem_rdata;
                        out_ip    <= res_ip_q;
                        out_sp    <= sp_q;
                        out_flags <= ent_flags;
                    end
                    S_POP_IP: begin
                        res_ip_q <= mem_rdata;
                        sp_q     <= sp_q + STEP;
                    end
                    S_POP_CS: begin
                        res_cs_q <= mem_rdata;
                        sp_q     <= sp_q + STEP;
                    end
                    S_POP_FL: begin
                        out_flags <= mem_rdata;
                        out_ip    <= res_ip_q;
                        out_cs    <= res_cs_q;
                        out_sp    <= sp_q + STEP;
                        sp_q      <= sp_q + STEP;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/swint_seq_chk.sv
module swint_seq_chk #(
    parameter int W         = 16,
    parameter int SEG_SHIFT = 4,
    parameter int OF_BIT    = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [1:0]             req_op,
    input logic [W-1:0]           in_flags,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [W+SEG_SHIFT-1:0] mem_addr,
    input logic [W-1:0]           mem_wdata,
    input logic                   mem_ack,
    input logic                   busy,
    input logic                   done
);
    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mem_req));

    // R6
    trap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd1 && !in_flags[OF_BIT]) |=> (done && !mem_req));

    // R10
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd3) |=> !busy);
endmodule

bind swint_seq swint_seq_chk #(.W(W), .SEG_SHIFT(SEG_SHIFT), .OF_BIT(OF_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .in_flags  (in_flags),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_swint_seq.sv
`timescale 1ns/1ps
module tb_swint_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [7:0]  req_type;
    logic [15:0] in_flags, in_cs, in_ip, in_ss, in_sp;
    logic        mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] out_flags, out_cs, out_ip, out_sp;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;
    logic [15:0] mem [int];

    always #2.5 clk = ~clk;

    swint_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_type(req_type),
        .in_flags(in_flags), .in_cs(in_cs), .in_ip(in_ip), .in_ss(in_ss), .in_sp(in_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .out_flags(out_flags), .out_cs(out_cs), .out_ip(out_ip), .out_sp(out_sp)
    );

    function automatic int rd(int a);
        return mem.exists(a) ? int'(mem[a]) : 0;
    endfunction

    function automatic int pa(int seg, int off);
        return ((seg << 4) + (off & 'hFFFF)) & 'hFFFFF;
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Reference model: expected access queue plus expected results, compared each cycle.
    task automatic run_op(input int op, input int tp, input int fl, input int cs, input int ip,
                          input int ss, input int sp, input int dly, input bit spam,
                          input string rq_res);
        int    q_a[$];
        bit    q_w[$];
        int    q_d[$];
        string q_t[$];
        int    e_ip, e_cs, e_sp, e_fl, v, cnt;
        bit    fin;
        cnt = 0;
        fin = 1'b0;
        if (op == 2) begin
            for (int k = 0; k < 3; k++) begin
                q_a.push_back(pa(ss, sp + 2*k)); q_w.push_back(1'b0); q_d.push_back(0); q_t.push_back("R7");
            end
            e_ip = rd(pa(ss, sp)); e_cs = rd(pa(ss, sp + 2)); e_fl = rd(pa(ss, sp + 4));
            e_sp = (sp + 6) & 'hFFFF;
        end else if (op == 1 && ((fl >> 11) & 1) == 0) begin
            e_ip = ip; e_cs = cs; e_sp = sp; e_fl = fl;
        end else begin
            v = (op == 1) ? 4 : tp;
            q_a.push_back(pa(ss, sp - 2)); q_w.push_back(1'b1); q_d.push_back(fl); q_t.push_back("R2");
            q_a.push_back(pa(ss, sp - 4)); q_w.push_back(1'b1); q_d.push_back(cs); q_t.push_back("R2");
            q_a.push_back(pa(ss, sp - 6)); q_w.push_back(1'b1); q_d.push_back(ip); q_t.push_back("R2");
            q_a.push_back(4*v);     q_w.push_back(1'b0); q_d.push_back(0); q_t.push_back("R3");
            q_a.push_back(4*v + 2); q_w.push_back(1'b0); q_d.push_back(0); q_t.push_back("R3");
            e_ip = rd(4*v); e_cs = rd(4*v + 2);
            e_sp = (sp - 6) & 'hFFFF; e_fl = fl & 'hFCFF;
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_type = 8'(tp);
        in_flags = 16'(fl); in_cs = 16'(cs); in_ip = 16'(ip); in_ss = 16'(ss); in_sp = 16'(sp);
        for (int it = 0; it < 200 && !fin; it++) begin
            @(negedge clk);
            if (q_a.size() > 0) begin
                chk("R9 busy during access", int'(busy), 1);
                chk("R9 done during access", int'(done), 0);
                chk({q_t[0], " mem_req"}, int'(mem_req), 1);
                chk({q_t[0], " mem_we"}, int'(mem_we), int'(q_w[0]));
                chk({q_t[0], " R8 mem_addr"}, int'(mem_addr), q_a[0]);
                if (q_w[0]) chk({q_t[0], " mem_wdata"}, int'(mem_wdata), q_d[0]);
                if (cnt == dly) begin
                    mem_ack = 1'b1;
                    if (q_w[0]) mem[q_a[0]] = mem_wdata;
                    else        mem_rdata = 16'(rd(q_a[0]));
                    void'(q_a.pop_front()); void'(q_w.pop_front());
                    void'(q_d.pop_front()); void'(q_t.pop_front());
                    cnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    cnt++;
                end
                if (spam) begin
                    req_valid = 1'b1; req_op = 2'd0; req_type = 8'h55; in_sp = 16'h0FF0;
                end else begin
                    req_valid = 1'b0;
                end
            end else begin
                mem_ack = 1'b0;
                req_valid = 1'b0;
                chk("R9 done pulse", int'(done), 1);
                chk("R9 busy at done", int'(busy), 1);
                chk("R8 no access at done", int'(mem_req), 0);
                chk({rq_res, " out_ip"}, int'(out_ip), e_ip);
                chk({rq_res, " out_cs"}, int'(out_cs), e_cs);
                chk({rq_res, " out_sp"}, int'(out_sp), e_sp);
                chk({rq_res, " out_flags"}, int'(out_flags), e_fl);
                fin = 1'b1;
            end
        end
        if (!fin) chk("R9 sequence finished", 0, 1);
        @(negedge clk);
        chk("R9 busy after done", int'(busy), 0);
        chk("R9 done after done", int'(done), 0);
        chk("R8 idle bus", int'(mem_req), 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_type = '0;
        in_flags = '0; in_cs = '0; in_ip = '0; in_ss = '0; in_sp = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        // vector table contents
        mem['h84]  = 16'hA1A1; mem['h86]  = 16'hB2B2;   // type 0x21
        mem['h0C]  = 16'h0C0C; mem['h0E]  = 16'h0E0E;   // type 3
        mem['h10]  = 16'h4410; mem['h12]  = 16'h4412;   // type 4
        mem['h3FC] = 16'hFCFC; mem['h3FE] = 16'hFEFE;   // type 255
        mem['h154] = 16'h5555; mem['h156] = 16'h5656;   // type 0x55 (must never be used)
        // return frame at 3000:0200
        mem[pa('h3000, 'h200)] = 16'h1111;
        mem[pa('h3000, 'h202)] = 16'h2222;
        mem[pa('h3000, 'h204)] = 16'h0ED7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 mem_req", int'(mem_req), 0);
        chk("R1 out_flags", int'(out_flags), 0);
        chk("R1 out_cs", int'(out_cs), 0);
        chk("R1 out_ip", int'(out_ip), 0);
        chk("R1 out_sp", int'(out_sp), 0);

        // R2 R3 R4: entry through vector 0x21, zero wait states
        run_op(0, 'h21, 'h0302, 'h1234, 'h5678, 'h2000, 'h0100, 0, 1'b0, "R4");
        // R7: return through the frame just built
        run_op(2, 0, 0, 0, 0, 'h2000, 'h00FA, 1, 1'b0, "R7");
        chk("R7 round trip flags", int'(out_flags), 'h0302);
        chk("R7 round trip cs", int'(out_cs), 'h1234);
        chk("R7 round trip ip", int'(out_ip), 'h5678);
        chk("R7 round trip sp", int'(out_sp), 'h0100);
        // R3 R4: breakpoint type 3 with two wait states
        run_op(0, 3, 'hFFFF, 'hCAFE, 'hBEEF, 'h2000, 'h0400, 2, 1'b0, "R4");
        // R2 R4: type 255, stack pointer and physical address wrap
        run_op(0, 255, 'h0100, 'h0001, 'h0002, 'hFFFF, 'h0002, 1, 1'b0, "R4");
        // R5 R10: overflow trap taken, requests while busy ignored
        run_op(1, 'h99, 'h0B00, 'h7000, 'h0123, 'h2000, 'h0800, 1, 1'b1, "R5");
        // R6: overflow trap not taken
        run_op(1, 'h21, 'h0302, 'h4321, 'h8765, 'h2000, 'h0600, 0, 1'b0, "R6");
        // R7: return with wait states from a preloaded frame
        run_op(2, 0, 0, 0, 0, 'h3000, 'h0200, 2, 1'b0, "R7");
        // R10: reserved operation code 3 is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_type = 8'h21; in_sp = 16'h0100;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R10 reserved busy", int'(busy), 0);
            chk("R10 reserved mem_req", int'(mem_req), 0);
            chk("R10 reserved done", int'(done), 0);
            @(negedge clk);
        end
        chk("R10 reserved out_sp", int'(out_sp), 'h0206);
        chk("R10 reserved out_ip", int'(out_ip), 'h1111);

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule